// File: doc/BRIEF.md
# Grouped GPIO Interrupt Aggregator

This block gathers interrupt requests from a large set of general-purpose input pins and folds them into one summary interrupt line for a processor. The pins are organised in groups of eight. Every pin has a 4-bit trigger-type field that chooses one of five trigger conditions: low level, high level, falling edge, rising edge or any edge. Every pin also has a pending flag that records a trigger, and a mask flag that decides whether the pending flag reaches the summary line.

Software sets up and services the block through a simple register port. The port takes a byte address, a write strobe with write data, and a read strobe with combinational read data. Configuration words, mask words and pending words sit in three separate banks, with one word per group. A handler reads the pending words, services the pins it owns, and clears them by writing ones. Each raw pin passes through a two-stage synchroniser before trigger detection, so the pins may be asynchronous to the clock.

Top module: `gpio_irq_hub`

## Requirements
- R1: While reset is held, every configuration word reads 0, every mask word reads 0x000000FF, every pending word reads 0 and `irq_o` is low.
- R2: For a group g below NUM_GROUPS, the configuration word is at byte address 0x700+4g, the mask word at 0x900+4g and the pending word at 0xA00+4g. Pin p's trigger field is configuration bits [4p+3:4p]. Pin p's mask and pending flags are bit p. Bits 31:8 of the mask and pending words read 0 and ignore writes.
- R3: A write to an address that is unmapped or not a multiple of four changes no register. A read of such an address returns 0. `bus_rdata_o` is 0 whenever `bus_rd_i` is low.
- R4: Trigger code 0 (low level) and code 1 (high level) set the pin's pending flag on every cycle that the synchronised pin shows the active level.
- R5: Code 2 sets pending on a 1-to-0 change of the synchronised pin. Code 3 sets it on a 0-to-1 change. Code 4 sets it on either change.
- R6: Trigger codes 5 to 15 never set a pending flag.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. Pending flags latch whether or not the pin is masked.
- R8: If a trigger and a write-1 clear of the same pending bit land in the same cycle, the pending bit ends up set.
- R9: `irq_o` is high exactly when some pending bit has its mask bit at 0. A mask bit of 1 keeps its pin off `irq_o`.
- R10: A pin change applied before clock edge k sets a pending flag no earlier than edge k+2, and by edge k+2 at the latest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 8*NUM_GROUPS | Raw pin levels; pin p of group g is bit 8g+p |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, one access per cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, combinational, 0 when no read is requested |
| irq_o | output | 1 | Summary interrupt |

## Verification
The in-line properties assume that the trigger code and the synchronised sample presented to a pin cell stay constant through the cycle they are judged in. They also assume that a clear reaches the cell only through a write strobe. Both assumptions hold because the register file changes its outputs only at clock edges. The bench changes pins and register accesses only on the falling clock edge. It holds the pin levels for several cycles before it reads pending words, so every synchroniser has settled. For the timing checks (R8 and R10), it counts edges exactly from the moment it changes a pin.

// File: rtl/girq_pkg.sv
// Package: shared constants and the trigger decision function for the
// grouped GPIO interrupt aggregator.
// Assumes: every group holds eight pins and each trigger field is 4 bits wide.
package girq_pkg;

    localparam int unsigned GRP_PINS = 8;
    localparam int unsigned FIELD_W  = 4;
    localparam int unsigned WORD_W   = GRP_PINS * FIELD_W;

    // Bank base byte offsets (group word = base + 4*group)
    localparam int unsigned CFG_BANK = 32'h700;
    localparam int unsigned MSK_BANK = 32'h900;
    localparam int unsigned PND_BANK = 32'hA00;

    // Trigger codes
    localparam logic [FIELD_W-1:0] TRG_LVL_LO    = 4'd0;
    localparam logic [FIELD_W-1:0] TRG_LVL_HI    = 4'd1;
    localparam logic [FIELD_W-1:0] TRG_EDGE_FALL = 4'd2;
    localparam logic [FIELD_W-1:0] TRG_EDGE_RISE = 4'd3;
    localparam logic [FIELD_W-1:0] TRG_EDGE_ANY  = 4'd4;

    // Decide whether a pin fires this cycle given its mode, its current
    // synchronised sample and the sample of the previous cycle.
    function automatic logic trig_fire(input logic [FIELD_W-1:0] mode,
                                       input logic cur,
                                       input logic prv);
        logic fire;
        case (mode)
            TRG_LVL_LO:    fire = !cur;
            TRG_LVL_HI:    fire = cur;
            TRG_EDGE_FALL: fire = prv && !cur;
            TRG_EDGE_RISE: fire = !prv && cur;
            TRG_EDGE_ANY:  fire = prv ^ cur;
            default:       fire = 1'b0;
        endcase
        return fire;
    endfunction

endpackage

// File: rtl/girq_sync.sv
// Module: girq_sync
// Two-stage synchroniser for a vector of asynchronous pin levels.
// Assumes: each bit is independent; no bus coherency is needed across bits.
module girq_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg1_q;
    logic [W-1:0] stg2_q;

    // Purpose: shift raw levels through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1_q <= '0;
            stg2_q <= '0;
        end else begin
            stg1_q <= d_i;
            stg2_q <= stg1_q;
        end
    end

    assign q_o = stg2_q;

endmodule

// File: rtl/girq_pin_cell.sv
// Module: girq_pin_cell
// Per-pin trigger detection and pending latch.
// Assumes: smp_i is already synchronised; clr_i is a one-cycle write-1 pulse.
// A trigger in the same cycle as a clear keeps the pending flag set.
module girq_pin_cell
    import girq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] mode_i,
    input  logic               smp_i,
    input  logic               clr_i,
    output logic               pend_o
);

    logic prv_q;
    logic pend_q;
    logic fire;

    // Purpose: remember last cycle's sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prv_q <= 1'b0;
        else        prv_q <= smp_i;
    end

    // Purpose: evaluate the selected trigger condition.
    always_comb begin
        fire = trig_fire(mode_i, smp_i, prv_q);
    end

    // Purpose: latch pending; a trigger overrides a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (fire)  pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !clr_i |=> pend_q); // R7
    AST_LVL_HI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRG_LVL_HI) && smp_i |=> pend_q); // R4
    AST_LVL_LO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRG_LVL_LO) && !smp_i |=> pend_q); // R4
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRG_EDGE_RISE) && smp_i && !prv_q |=> pend_q); // R5
    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRG_EDGE_ANY) && (smp_i != prv_q) && clr_i |=> pend_q); // R8
    AST_INERT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i > TRG_EDGE_ANY) && !pend_q |=> !pend_q); // R6
    AST_INERT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i > TRG_EDGE_ANY) && clr_i |=> !pend_q); // R7

endmodule

// File: rtl/girq_regs.sv
// Module: girq_regs
// Register file: configuration and mask words per group, address decode,
// write-1 clear pulses for pending bits and the combinational read mux.
// Assumes: byte addressing with a 4-byte stride; one access per cycle.
module girq_regs
    import girq_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 21,
    parameter int unsigned ADDR_W     = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic                             wr_i,
    input  logic [WORD_W-1:0]                wdata_i,
    input  logic                             rd_i,
    output logic [WORD_W-1:0]                rdata_o,
    input  logic [NUM_GROUPS*GRP_PINS-1:0]   pend_i,
    output logic [NUM_GROUPS*WORD_W-1:0]     cfg_o,
    output logic [NUM_GROUPS*GRP_PINS-1:0]   mask_o,
    output logic [NUM_GROUPS*GRP_PINS-1:0]   clr_o
);

    localparam int unsigned NPIN = NUM_GROUPS * GRP_PINS;

    logic [NUM_GROUPS-1:0][WORD_W-1:0]   cfg_q;
    logic [NUM_GROUPS-1:0][GRP_PINS-1:0] msk_q;
    logic [NUM_GROUPS-1:0]               hit_cfg;
    logic [NUM_GROUPS-1:0]               hit_msk;
    logic [NUM_GROUPS-1:0]               hit_pnd;

    // Purpose: decode the byte address into per-group bank hits.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            hit_cfg[g] = (addr_i == ADDR_W'(CFG_BANK + 4 * g));
            hit_msk[g] = (addr_i == ADDR_W'(MSK_BANK + 4 * g));
            hit_pnd[g] = (addr_i == ADDR_W'(PND_BANK + 4 * g));
        end
    end

    // Purpose: hold configuration and mask words, updated by bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            msk_q <= '1;
        end else if (wr_i) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (hit_cfg[g]) cfg_q[g] <= wdata_i;
                if (hit_msk[g]) msk_q[g] <= wdata_i[GRP_PINS-1:0];
            end
        end
    end

    // Purpose: flatten state and form write-1 clear pulses per group.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_flat
        assign cfg_o[g*WORD_W +: WORD_W]     = cfg_q[g];
        assign mask_o[g*GRP_PINS +: GRP_PINS] = msk_q[g];
        assign clr_o[g*GRP_PINS +: GRP_PINS]  =
            (wr_i && hit_pnd[g]) ? wdata_i[GRP_PINS-1:0] : '0;
    end

    // Purpose: combinational read mux, zero when idle or unmapped.
    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (hit_cfg[g]) rdata_o = rdata_o | cfg_q[g];
                if (hit_msk[g]) rdata_o = rdata_o | WORD_W'(msk_q[g]);
                if (hit_pnd[g]) rdata_o = rdata_o | WORD_W'(pend_i[g*GRP_PINS +: GRP_PINS]);
            end
        end
    end

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> (rdata_o == '0)); // R3
    AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |-> (clr_o == {NPIN{1'b0}})); // R7
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o)); // R2

endmodule

// File: rtl/gpio_irq_hub.sv
// Module: gpio_irq_hub (top)
// Grouped GPIO interrupt aggregator: synchronises raw pins, detects the
// per-pin trigger, latches pending flags and ORs unmasked ones onto irq_o.
// Assumes: pins may be asynchronous; the bus is synchronous to clk.
module gpio_irq_hub
    import girq_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 21,
    parameter int unsigned ADDR_W     = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_GROUPS*GRP_PINS-1:0] pins_i,
    input  logic [ADDR_W-1:0]              bus_addr_i,
    input  logic                           bus_wr_i,
    input  logic [WORD_W-1:0]              bus_wdata_i,
    input  logic                           bus_rd_i,
    output logic [WORD_W-1:0]              bus_rdata_o,
    output logic                           irq_o
);

    localparam int unsigned NPIN = NUM_GROUPS * GRP_PINS;

    logic [NPIN-1:0]              smp;
    logic [NPIN-1:0]              pend;
    logic [NPIN-1:0]              mask;
    logic [NPIN-1:0]              clr;
    logic [NUM_GROUPS*WORD_W-1:0] cfg;

    girq_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i),
        .q_o   (smp)
    );

    girq_regs #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr_i),
        .wr_i    (bus_wr_i),
        .wdata_i (bus_wdata_i),
        .rd_i    (bus_rd_i),
        .rdata_o (bus_rdata_o),
        .pend_i  (pend),
        .cfg_o   (cfg),
        .mask_o  (mask),
        .clr_o   (clr)
    );

    // Purpose: one trigger/pending cell per pin.
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        girq_pin_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_i (cfg[i*FIELD_W +: FIELD_W]),
            .smp_i  (smp[i]),
            .clr_i  (clr[i]),
            .pend_o (pend[i])
        );
    end

    // Purpose: summary interrupt from pending flags that are not masked.
    assign irq_o = |(pend & ~mask);

    AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq_o); // R9
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq_o); // R9

endmodule

// File: tb/tb_gpio_irq_hub.sv
module tb_gpio_irq_hub;

    localparam int CLK_P = 10;
    localparam int NG    = 3;
    localparam int NP    = NG * 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   pins = '0;
    logic [11:0]     addr = '0;
    logic            wr = 1'b0;
    logic [31:0]     wdata = '0;
    logic            rd = 1'b0;
    logic [31:0]     rdata;
    logic            irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    gpio_irq_hub #(.NUM_GROUPS(NG), .ADDR_W(12)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (pins),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [11:0] a_cfg(int g); return 12'(32'h700 + 4*g); endfunction
    function automatic logic [11:0] a_msk(int g); return 12'(32'h900 + 4*g); endfunction
    function automatic logic [11:0] a_pnd(int g); return 12'(32'hA00 + 4*g); endfunction

    // Expected trigger per requirement: level codes 0/1, edge codes 2/3/4.
    function automatic bit exp_pend(int m, bit a, bit b);
        case (m)
            0: return (!a) || (!b);
            1: return a || b;
            2: return a && !b;
            3: return !a && b;
            4: return a != b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = '0; wdata = '0;
    endtask

    // Read right now (caller is away from the rising edge).
    task automatic read_now(input logic [11:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        rd = 1'b0; addr = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        read_now(a, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int g = 0; g < NG; g++) bus_write(a_pnd(g), 32'hFF);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  exp8;
        int modes [8] = '{0, 1, 2, 3, 4, 5, 6, 15};

        // R1: reset values observed while reset is held
        idle(3);
        for (int g = 0; g < NG; g++) begin
            read_now(a_cfg(g), d); check(d, 32'h0, "R1 cfg reset");
            read_now(a_msk(g), d); check(d, 32'hFF, "R1 mask reset");
            read_now(a_pnd(g), d); check(d, 32'h0, "R1 pend reset");
        end
        check({31'b0, irq}, 32'h0, "R1 irq reset");
        @(negedge clk); rst_n = 1'b1;

        // R2: readback and field widths
        bus_write(a_cfg(1), 32'h1234_5678);
        bus_read(a_cfg(1), d); check(d, 32'h1234_5678, "R2 cfg readback");
        bus_write(a_msk(0), 32'hFFFF_FF5A);
        bus_read(a_msk(0), d); check(d, 32'h5A, "R2 mask upper bits");
        // R3: misaligned and unmapped accesses
        bus_write(12'h902, 32'h0);
        bus_read(a_msk(0), d); check(d, 32'h5A, "R3 misaligned write ignored");
        bus_write(a_cfg(NG), 32'hFFFF_FFFF);
        bus_read(a_cfg(NG), d); check(d, 32'h0, "R3 unmapped read");
        bus_read(a_cfg(0), d); check(d, 32'h0, "R3 unmapped write ignored");
        bus_read(12'h800, d); check(d, 32'h0, "R3 gap read");
        @(negedge clk); addr = a_msk(0); rd = 1'b0; #1;
        check(rdata, 32'h0, "R3 idle rdata");
        addr = '0;
        bus_write(a_msk(0), 32'hFF);

        // R4/R5/R6: sweep every mode over all four transitions on each pin
        foreach (modes[k]) begin
            int m = modes[k];
            for (int g = 0; g < NG; g++) bus_write(a_cfg(g), {8{m[3:0]}});
            @(negedge clk);
            for (int i = 0; i < NP; i++) pins[i] = (i % 8) & 1;
            idle(5);
            clear_all();
            @(negedge clk);
            for (int i = 0; i < NP; i++) pins[i] = ((i % 8) >> 1) & 1;
            idle(5);
            for (int g = 0; g < NG; g++) begin
                for (int p = 0; p < 8; p++) exp8[p] = exp_pend(m, p & 1, (p >> 1) & 1);
                bus_read(a_pnd(g), d);
                if (m <= 1)      check(d, {24'b0, exp8}, "R4 level sweep");
                else if (m <= 4) check(d, {24'b0, exp8}, "R5 edge sweep");
                else             check(d, {24'b0, exp8}, "R6 inert code");
            end
            check({31'b0, irq}, 32'h0, "R9 masked during sweep");
        end

        // R9/R7: masking and write-1 clear
        for (int g = 0; g < NG; g++) bus_write(a_cfg(g), {8{4'd3}});
        @(negedge clk); pins = '0;
        idle(5);
        clear_all();
        @(negedge clk); pins[2*8+5] = 1'b1;
        idle(4);
        check({31'b0, irq}, 32'h0, "R9 masked pin blocked");
        bus_read(a_pnd(2), d); check(d, 32'h20, "R7 latch while masked");
        bus_write(a_msk(2), 32'hDF);
        @(negedge clk); check({31'b0, irq}, 32'h1, "R9 unmasked raises irq");
        bus_write(a_pnd(2), 32'h0);
        bus_read(a_pnd(2), d); check(d, 32'h20, "R7 write 0 no effect");
        bus_write(a_pnd(2), 32'h20);
        bus_read(a_pnd(2), d); check(d, 32'h0, "R7 write 1 clears");
        check({31'b0, irq}, 32'h0, "R9 irq drops after clear");
        bus_write(a_msk(2), 32'hFF);

        // R10: two-cycle synchroniser latency
        @(negedge clk); pins[0] = 1'b1;          // before edge k
        @(negedge clk);                           // after k
        @(negedge clk); read_now(a_pnd(0), d);    // after k+1
        check(d, 32'h0, "R10 not before k+2");
        @(negedge clk); read_now(a_pnd(0), d);    // after k+2
        check(d, 32'h1, "R10 set at k+2");
        bus_write(a_pnd(0), 32'h1);

        // R8: trigger and clear in the same cycle
        @(negedge clk); pins[1] = 1'b1;          // before edge k
        @(negedge clk);                           // after k
        @(negedge clk);                           // after k+1
        addr = a_pnd(0); wdata = 32'h2; wr = 1'b1;
        @(negedge clk);                           // after k+2
        wr = 1'b0; addr = '0; wdata = '0;
        bus_read(a_pnd(0), d); check(d, 32'h2, "R8 event beats clear");
        bus_write(a_pnd(0), 32'h2);
        bus_read(a_pnd(0), d); check(d, 32'h0, "R7 later clear works");

        // R4: level re-asserts after a clear while active
        bus_write(a_cfg(1), {8{4'd1}});
        @(negedge clk); pins[8] = 1'b1;
        idle(4);
        bus_write(a_pnd(1), 32'hFF);
        bus_read(a_pnd(1), d); check(d, 32'h1, "R4 level persists over clear");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule